// File: doc/BRIEF.md
# Quad-Lane Flash Read Engine

This block serves a simple system-bus read port by running one serial flash read for each request and returning a single 32-bit word. Every access goes through four phases in a fixed order. First an 8-bit opcode goes out on one line. Then the address goes out on one line or on four, and it is 24 or 32 bits wide. Next comes a run of turnaround clocks, which also covers any mode bits the flash expects. Last, eight clocks of four-lane read data come in. The opcode is sent again on every access.

The serial clock comes from the module clock through an even divider. The data lines are split into output, output-enable and input vectors, and the pad ring builds the bidirectional pins from them. The transfer uses clock mode 0: outputs change on the falling edge and inputs are sampled on the rising edge. A byte-order stage chooses how the four received bytes are packed into the returned word. All settings are taken from the configuration inputs at the moment a request is accepted and are held for the whole transaction.

Top module: `qspi_xip_reader`

## Requirements
- R1: Each serial clock high time and each low time last h module cycles, where h = cfg_div >> 1 (bit 0 of the divider is ignored). A result of 0 is taken as h = 1.
- R2: Selection timing. cs_n falls on the clock edge that accepts a request, and the first rising sclk edge follows h cycles later. sclk is low whenever cs_n is high. cs_n rises on the falling sclk edge that ends the last data clock. It then stays high for at least 4h cycles before the next select.
- R3: The opcode takes 8 clocks, most significant bit first, on io_out[0] with io_oe = 4'b0001.
- R4: The address is req_addr when cfg_addr_wide=1, or req_addr[23:0] when it is 0, sent most significant bit first. With cfg_addr_quad=1 it goes out a nibble per clock on io_out[3:0] (io_out[3] carries the nibble's top bit) with io_oe = 4'b1111, taking 8 or 6 clocks. With cfg_addr_quad=0 it goes out a bit per clock on io_out[0] with io_oe = 4'b0001, taking 32 or 24 clocks.
- R5: After the address come exactly cfg_dummy turnaround clocks, followed by 8 data clocks. io_oe is 0 throughout both of these phases.
- R6: Each data clock samples io_in[3:0] at its rising edge. The first nibble is the high half of the first received byte.
- R7: Let b0..b3 be the bytes in the order they arrive. Byte order cfg_endian=1 gives {b0,b1,b2,b3}, 2 gives {b2,b3,b0,b1}, and 0 or 3 give {b3,b2,b1,b0} (written most significant byte first).
- R8: req_ready is high only while the engine is idle. rsp_valid is a one-cycle pulse that comes one cycle after cs_n rises, and rsp_data is valid with it.
- R9: The configuration inputs and req_addr are sampled only when a request is accepted. Changing them during a transaction has no effect on that transaction.
- R10: Every transaction, including back-to-back ones, begins with the full opcode phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_instr | input | 8 | Opcode byte |
| cfg_addr_wide | input | 1 | 1: 32-bit address, 0: 24-bit |
| cfg_addr_quad | input | 1 | 1: address on four lanes, 0: on one lane |
| cfg_dummy | input | DUMMY_W | Turnaround clock count, mode bits included |
| cfg_div | input | DIV_W | Serial clock divider (even) |
| cfg_endian | input | 2 | Byte packing select |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_addr | input | 32 | Flash byte address |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 32 | Read data word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The assertions take for granted that reset is held for at least one clock edge. They also assume the divider yields a half period of at least one cycle, which the halving function guarantees for any input value. The assertions ignore the configuration inputs and req_addr between acceptances, because the engine works only from its captured copies. The stimulus changes every configuration input and the address right after each acceptance, which exercises that assumption. The bench acts as the flash: it drives io_in only after a falling sclk edge, so the value is settled before the rising edge that samples it.

// File: rtl/qxr_pkg.sv
package qxr_pkg;
  localparam int INSTR_CLKS = 8;
  localparam int DATA_CLKS  = 8;

  typedef enum logic [1:0] {PH_INSTR, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  // clocks needed for the address phase
  function automatic logic [5:0] addr_clocks(input logic wide, input logic quad);
    if (quad) return wide ? 6'd8 : 6'd6;
    return wide ? 6'd32 : 6'd24;
  endfunction

  // raw holds the first received byte in [31:24]
  function automatic logic [31:0] reorder(input logic [31:0] raw, input logic [1:0] mode);
    case (mode)
      2'd1:    return raw;
      2'd2:    return {raw[15:8], raw[7:0], raw[31:24], raw[23:16]};
      default: return {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
    endcase
  endfunction
endpackage

// File: rtl/qxr_clkgen.sv
module qxr_clkgen #(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + HALF_W'(1);
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
endmodule

// File: rtl/qxr_sequencer.sv
module qxr_sequencer import qxr_pkg::*; #(
  parameter int DUMMY_W = 8,
  parameter int IDX_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               tick,
  input  logic [7:0]         instr,
  input  logic [31:0]        addr,
  input  logic               wide,
  input  logic               quad,
  input  logic [DUMMY_W-1:0] dummy,
  input  logic [3:0]         io_in,
  output logic               idle,
  output logic               sclk,
  output logic               cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  output logic               done,
  output logic [31:0]        raw
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_e;
  state_e state;
  logic [IDX_W-1:0] idx;
  logic [1:0] gap;

  logic [IDX_W-1:0] a_end, d_end, t_end;
  phase_e phase;
  logic [31:0] aligned;
  logic [4:0]  aj;
  logic ev_rise, ev_fall, last_clk;

  assign a_end    = IDX_W'(INSTR_CLKS) + IDX_W'(addr_clocks(wide, quad));
  assign d_end    = a_end + IDX_W'(dummy);
  assign t_end    = d_end + IDX_W'(DATA_CLKS);
  assign aligned  = wide ? addr : {addr[23:0], 8'h00};
  assign aj       = 5'(idx - IDX_W'(INSTR_CLKS));
  assign idle     = (state == S_IDLE);
  assign ev_rise  = (state == S_SHIFT) && tick && !sclk;
  assign ev_fall  = (state == S_SHIFT) && tick && sclk;
  assign last_clk = (idx == t_end - IDX_W'(1));

  always_comb begin
    if (idx < IDX_W'(INSTR_CLKS)) phase = PH_INSTR;
    else if (idx < a_end)         phase = PH_ADDR;
    else if (idx < d_end)         phase = PH_DUMMY;
    else                          phase = PH_DATA;
  end

  // lane drive for the current clock index
  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    if (state == S_SHIFT) begin
      if (phase == PH_INSTR) begin
        io_out[0] = instr[3'd7 - idx[2:0]];
        io_oe     = 4'b0001;
      end else if (phase == PH_ADDR) begin
        if (quad) begin
          io_out = aligned[5'd31 - {aj[2:0], 2'b00} -: 4];
          io_oe  = 4'b1111;
        end else begin
          io_out[0] = aligned[5'd31 - aj];
          io_oe     = 4'b0001;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      gap   <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
      raw   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_SHIFT;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          idx   <= '0;
        end
        S_SHIFT: begin
          if (ev_rise) begin
            sclk <= 1'b1;
            if (phase == PH_DATA) raw <= {raw[27:0], io_in};
          end
          if (ev_fall) begin
            sclk <= 1'b0;
            if (last_clk) begin
              cs_n  <= 1'b1;
              state <= S_GAP;
              gap   <= '0;
              done  <= 1'b1;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: if (tick) begin
          gap <= gap + 2'd1;
          if (gap == 2'd3) state <= S_IDLE;
        end
      endcase
    end
  end

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && io_oe == 4'b0000));
  p_sclk_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));
  p_cs_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) && !sclk));
  p_instr_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && phase == PH_INSTR) |-> (io_oe == 4'b0001));
  p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY || phase == PH_DATA) |-> (io_oe == 4'b0000));
endmodule

// File: rtl/qxr_endian.sv
module qxr_endian import qxr_pkg::*; (
  input  logic [31:0] raw,
  input  logic [1:0]  mode,
  output logic [31:0] word
);
  assign word = reorder(raw, mode);
endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader import qxr_pkg::*; #(
  parameter int DIV_W   = 16,
  parameter int DUMMY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_instr,
  input  logic               cfg_addr_wide,
  input  logic               cfg_addr_quad,
  input  logic [DUMMY_W-1:0] cfg_dummy,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [1:0]         cfg_endian,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic               sclk,
  output logic               cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in
);
  localparam int HALF_W = DIV_W - 1;
  localparam int IDX_W  = $clog2(INSTR_CLKS + 32 + (1 << DUMMY_W) + DATA_CLKS);

  // half period in module cycles; bit 0 of the divider is dropped
  function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] d);
    logic [HALF_W-1:0] h;
    h = d[DIV_W-1:1];
    return (h == '0) ? HALF_W'(1) : h;
  endfunction

  logic               idle, start, tick, done;
  logic [31:0]        raw, word;
  logic [7:0]         sh_instr;
  logic [31:0]        sh_addr;
  logic               sh_wide, sh_quad;
  logic [DUMMY_W-1:0] sh_dummy;
  logic [HALF_W-1:0]  sh_half;
  logic [1:0]         sh_endian;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_instr  <= '0;
      sh_addr   <= '0;
      sh_wide   <= 1'b0;
      sh_quad   <= 1'b0;
      sh_dummy  <= '0;
      sh_half   <= HALF_W'(1);
      sh_endian <= '0;
    end else if (start) begin
      sh_instr  <= cfg_instr;
      sh_addr   <= req_addr;
      sh_wide   <= cfg_addr_wide;
      sh_quad   <= cfg_addr_quad;
      sh_dummy  <= cfg_dummy;
      sh_half   <= half_of(cfg_div);
      sh_endian <= cfg_endian;
    end
  end

  qxr_clkgen #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(!idle), .half(sh_half), .tick(tick)
  );

  qxr_sequencer #(.DUMMY_W(DUMMY_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .instr(sh_instr), .addr(sh_addr), .wide(sh_wide), .quad(sh_quad),
    .dummy(sh_dummy), .io_in(io_in), .idle(idle), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .done(done), .raw(raw)
  );

  qxr_endian u_end (.raw(raw), .mode(sh_endian), .word(word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done;
      if (done) rsp_data <= word;
    end
  end

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_ready_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(sh_instr) && $stable(sh_addr) && $stable(sh_half)
                    && $stable(sh_dummy) && $stable(sh_endian)));
endmodule

// File: tb/qspi_xip_reader_test.sv
module qspi_xip_reader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  cfg_instr = '0;
  logic        cfg_addr_wide = 1'b0, cfg_addr_quad = 1'b0;
  logic [7:0]  cfg_dummy = '0;
  logic [15:0] cfg_div = '0;
  logic [1:0]  cfg_endian = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  io_in = '0;
  logic        req_ready, rsp_valid, sclk, cs_n;
  logic [31:0] rsp_data;
  logic [3:0]  io_out, io_oe;

  qspi_xip_reader uut (
    .clk(clk), .rst_n(rst_n), .cfg_instr(cfg_instr), .cfg_addr_wide(cfg_addr_wide),
    .cfg_addr_quad(cfg_addr_quad), .cfg_dummy(cfg_dummy), .cfg_div(cfg_div),
    .cfg_endian(cfg_endian), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sclk(sclk),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  typedef struct {
    logic [7:0]  instr;
    logic [31:0] addr;
    logic        wide;
    logic        quad;
    int          dummy;
    int          half;
    logic [31:0] data;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] pack(input logic [31:0] a, input logic [1:0] en);
    logic [7:0] b0, b1, b2, b3;
    b0 = mem_byte(a); b1 = mem_byte(a + 1); b2 = mem_byte(a + 2); b3 = mem_byte(a + 3);
    if (en == 2'd1) return {b0, b1, b2, b3};
    if (en == 2'd2) return {b2, b3, b0, b1};
    return {b3, b2, b1, b0};
  endfunction

  function automatic int addr_len(input logic w, input logic qd);
    if (qd) return w ? 8 : 6;
    return w ? 32 : 24;
  endfunction

  // driver: present a request, queue the expectation, then disturb the inputs (R9)
  task automatic issue(input logic [7:0] ins, input logic [31:0] a, input logic w,
                       input logic qd, input int dum, input int div, input logic [1:0] en);
    exp_t e;
    @(negedge clk);
    cfg_instr = ins; cfg_addr_wide = w; cfg_addr_quad = qd;
    cfg_dummy = 8'(dum); cfg_div = 16'(div); cfg_endian = en;
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e.instr = ins;
    e.addr  = w ? a : {8'h00, a[23:0]};
    e.wide  = w; e.quad = qd; e.dummy = dum;
    e.half  = ((div >> 1) == 0) ? 1 : (div >> 1);
    e.data  = pack(e.addr, en);
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_instr = ~ins; cfg_addr_wide = ~w; cfg_addr_quad = ~qd;
    cfg_dummy = 8'(dum + 3); cfg_div = 16'(div + 4); cfg_endian = en + 2'd1;
    req_addr = ~a;
  endtask

  // monitor and flash model
  exp_t cur;
  bit active = 0, prev_cs = 1, prev_sclk = 0, have_prev = 0, rsp_due = 0, pulse_chk = 0;
  bit oe_bad_i, oe_bad_a, oe_bad_d, half_bad, ready_bad;
  int cyc = 0, gap_cyc = 0, last_half = 1, rises = 0;
  logic [7:0]  ins_c;
  logic [31:0] addr_c;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (cs_n) gap_cyc++;
      if (prev_cs && !cs_n) begin
        if (q.size() == 0) begin
          check(0, "R8", "select without accepted request", 0, 1);
        end else begin
          cur = q[0];
          if (have_prev) check(gap_cyc >= 4 * last_half, "R2", "deselect gap", gap_cyc, 4 * last_half);
          active = 1; rises = 0; ins_c = '0; addr_c = '0; cyc = 0;
          oe_bad_i = 0; oe_bad_a = 0; oe_bad_d = 0; half_bad = 0; ready_bad = 0;
        end
      end else if (active && !cs_n && sclk != prev_sclk) begin
        int ac, ds;
        ac = addr_len(cur.wide, cur.quad);
        ds = 8 + ac + cur.dummy;
        if (cyc != cur.half) half_bad = 1;
        cyc = 0;
        if (sclk) begin
          if (rises < 8) begin
            ins_c = {ins_c[6:0], io_out[0]};
            if (io_oe != 4'b0001) oe_bad_i = 1;
          end else if (rises < 8 + ac) begin
            if (cur.quad) begin
              addr_c = {addr_c[27:0], io_out};
              if (io_oe != 4'b1111) oe_bad_a = 1;
            end else begin
              addr_c = {addr_c[30:0], io_out[0]};
              if (io_oe != 4'b0001) oe_bad_a = 1;
            end
          end else if (io_oe != 4'b0000) oe_bad_d = 1;
          rises++;
        end else begin
          if (rises >= ds && rises < ds + 8) begin
            int j;
            logic [7:0] b;
            j = rises - ds;
            b = mem_byte(addr_c + 32'(j / 2));
            io_in = (j % 2 == 0) ? b[7:4] : b[3:0];
          end else io_in = 4'h0;
        end
      end else if (active && cs_n) begin
        int tot;
        tot = 8 + addr_len(cur.wide, cur.quad) + cur.dummy + 8;
        if (cyc != cur.half) half_bad = 1;
        check(!half_bad, "R1", "sclk half period", half_bad, 0);
        check(sclk == 1'b0, "R2", "sclk low at deselect", sclk, 0);
        check(rises == tot, "R2 R5", "clock count per access", rises, tot);
        check(ins_c == cur.instr, "R3 R10", "opcode bits", ins_c, cur.instr);
        check(!oe_bad_i, "R3", "opcode lane enables", oe_bad_i, 0);
        check(addr_c == cur.addr, "R4", "address bits", addr_c, cur.addr);
        check(!oe_bad_a, "R4", "address lane enables", oe_bad_a, 0);
        check(!oe_bad_d, "R5", "enables released", oe_bad_d, 0);
        check(!ready_bad, "R8", "ready low while selected", ready_bad, 0);
        active = 0; gap_cyc = 0; last_half = cur.half; have_prev = 1; rsp_due = 1;
        io_in = 4'h0;
      end else if (rsp_due) begin
        check(rsp_valid == 1'b1, "R8", "response one cycle after deselect", rsp_valid, 1);
        check(rsp_data == cur.data, "R6 R7", "returned word", rsp_data, cur.data);
        void'(q.pop_front());
        rsp_due = 0; pulse_chk = 1;
      end else if (pulse_chk) begin
        check(rsp_valid == 1'b0, "R8", "response pulse width", rsp_valid, 0);
        pulse_chk = 0;
      end
      if (active && !cs_n && req_ready) ready_bad = 1;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0, "R2", "reset lines", {cs_n, sclk}, 2'b10);
    check(io_oe == 4'b0000, "R2", "reset enables", io_oe, 0);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R8", "reset handshake", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    issue(8'hEB, 32'h1234_5678, 1'b1, 1'b1, 6, 2, 2'd0);  // R4 wide quad, R7 mode 0
    issue(8'hEB, 32'hAB00_0104, 1'b0, 1'b1, 4, 5, 2'd1);  // R1 odd divider, R7 mode 1
    issue(8'h0B, 32'h0000_3C21, 1'b0, 1'b0, 8, 0, 2'd2);  // R1 zero divider, R4 single lane
    issue(8'h6B, 32'hFEDC_BA98, 1'b1, 1'b0, 0, 6, 2'd3);  // R5 no turnaround, R7 mode 3
    issue(8'hEB, 32'h0000_0FF0, 1'b1, 1'b1, 6, 3, 2'd1);  // R10 back to back
    issue(8'hEB, 32'h7FFF_FFFE, 1'b1, 1'b1, 2, 4, 2'd2);
    while (q.size() != 0 || rsp_due || pulse_chk) @(negedge clk);
    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule